// File: doc/BRIEF.md
# I2C Bus Protocol Trigger Detector

This block watches an I2C clock/data pair that has already been sampled into the system clock domain. It raises a one-cycle trigger pulse when a chosen bus condition appears. The condition can be a stop condition, a missing acknowledge, an address match, a data-pattern match, or an address match followed by a data match in the same transfer. The address can be 7, 8 or 10 bits wide. The data pattern is one to five bytes long, and each of its bits can be required high, required low or ignored.

All configuration inputs are static while the bus is watched. Bits are taken on the rising edge of SCL. A start condition, or a repeated start, restarts byte and bit counting. A stop condition returns everything to idle. The pulse can be used to freeze a capture buffer or to start an external counter.

Top module: `i2c_trig_det`

## Requirements
- R1: While `rstN` is low, and afterwards on an idle bus (SCL and SDA high), `trigOut` stays low.
- R2: Each detected condition produces exactly one `trigOut` pulse, one clock cycle long, in the clock cycle after the sample that completes the condition.
- R3: SDA falling while SCL is high is a start. A start that comes in the middle of a transfer resets bit and byte counting, so address decoding restarts at the next byte. SDA rising while SCL is high is a stop, and it ends the transfer.
- R4: With `cfgMode`=0 (stop), every stop condition fires the trigger.
- R5: With `cfgMode`=1 (lost acknowledge), the trigger fires on the ninth SCL rise of each byte inside a transfer when SDA is high.
- R6: With `cfgAddrWidth`=0 (7-bit), the first byte after a start is read MSB first. Its bits 7..1 must equal `cfgAddr[6:0]` and its bit 0 (1 = read) must equal `cfgDirRead`. In address mode (`cfgMode`=2) the trigger fires on that direction bit.
- R7: With `cfgAddrWidth`=1 (8-bit), the whole first byte must equal `cfgAddr[7:0]` and `cfgDirRead` has no effect. In address mode the trigger fires on the eighth bit.
- R8: With `cfgAddrWidth`=2 (10-bit), the first byte must be `11110`, then `cfgAddr[9:8]`, then the direction bit matching `cfgDirRead`. The second byte must equal `cfgAddr[7:0]`. In address mode the trigger fires on the last bit of the second byte.
- R9: With `cfgMode`=3 (data), pattern bit k (k = 0 to 8*`cfgDataLen`-1) is the k-th data bit on the bus after the address bytes, counted MSB first with acknowledge bits skipped. Where `cfgDataCare[k]`=1 that bit must equal `cfgDataVal[k]`. The trigger fires on the SCL rise of the last pattern bit.
- R10: With `cfgMode`=4 (address and data), the trigger fires at the last pattern bit only if the address matched earlier in the same transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level |
| cfgMode | input | 3 | Condition select: 0 stop, 1 lost ack, 2 address, 3 data, 4 address+data |
| cfgAddrWidth | input | 2 | Address width: 0 = 7-bit, 1 = 8-bit, 2 = 10-bit |
| cfgAddr | input | ADDR_W (10) | Address to match |
| cfgDirRead | input | 1 | Direction to match (1 = read); ignored for 8-bit |
| cfgDataLen | input | LEN_W (3) | Pattern length in bytes, 1 to DATA_BYTES |
| cfgDataVal | input | 8*DATA_BYTES (40) | Required value of each pattern bit |
| cfgDataCare | input | 8*DATA_BYTES (40) | 1 = bit compared, 0 = don't care |
| trigOut | output | 1 | One-cycle trigger pulse |

## Verification
On every cycle, the assertions check three things: the trigger pulse is one cycle wide, a stop-mode pulse follows a sample with SDA and SCL both high, and a lost-acknowledge pulse follows a high SDA sample. They also check that a start or stop empties the bit, byte and pattern counters, and that those counters stay in range. The remaining behaviour needs the bench scenarios to show it, because it depends on whole transfers. That covers which bit position a match fires on, the role of the 10-bit prefix, the 8-bit mode ignoring the direction, the pattern masks, and the re-arming of address decoding by a repeated start.

// File: rtl/i2c_trig_pkg.sv
package i2c_trig_pkg;

  typedef enum logic [2:0] {
    TRG_STOP      = 3'd0,
    TRG_NACK      = 3'd1,
    TRG_ADDR      = 3'd2,
    TRG_DATA      = 3'd3,
    TRG_ADDR_DATA = 3'd4
  } trigMode_e;

  typedef enum logic [1:0] {
    AW_7  = 2'd0,
    AW_8  = 2'd1,
    AW_10 = 2'd2
  } addrWidth_e;

  // bus events decoded by the datapath
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sdaBit;
  } busEv_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic dataBit;
  } ctlStrobe_t;

endpackage

// File: rtl/i2c_trig_dp.sv
module i2c_trig_dp
  import i2c_trig_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [DATA_W-1:0] cfgDataVal,
  input  logic [DATA_W-1:0] cfgDataCare,
  input  ctlStrobe_t        strobe,
  output busEv_t            ev,
  output logic [3:0]        bitCnt,
  output logic [2:0]        byteCnt,
  output logic [7:0]        curByte,
  output logic [IDX_W-1:0]  dataIdx,
  output logic              dataOk,
  output logic              patBitOk
);

  logic       sclQ, sdaQ;
  logic [6:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign ev.startEv = sclIn & sclQ & sdaQ & ~sdaIn;
  assign ev.stopEv  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign ev.sclRise = sclIn & ~sclQ;
  assign ev.sdaBit  = sdaIn;

  // bit / byte position within the transfer
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrFrame) begin
      bitCnt   <= '0;
      byteCnt  <= '0;
      shiftReg <= '0;
    end else if (ev.sclRise) begin
      if (bitCnt == 4'd8) begin
        bitCnt <= '0;
        if (byteCnt != '1) byteCnt <= byteCnt + 3'd1;
      end else begin
        bitCnt   <= bitCnt + 4'd1;
        shiftReg <= {shiftReg[5:0], sdaIn};
      end
    end
  end

  assign curByte = {shiftReg, sdaIn};

  // pattern comparison, one bit per data clock
  assign patBitOk = ~cfgDataCare[dataIdx] | (cfgDataVal[dataIdx] == sdaIn);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrFrame) begin
      dataIdx <= '0;
      dataOk  <= 1'b1;
    end else if (strobe.dataBit) begin
      dataIdx <= dataIdx + IDX_W'(1);
      dataOk  <= dataOk & patBitOk;
    end
  end

  a_r3_frame_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFrame |=> (bitCnt == 4'd0 && byteCnt == 3'd0 && dataIdx == '0 && dataOk));

  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);

  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    dataIdx <= IDX_W'(DATA_W));

endmodule

// File: rtl/i2c_trig_ctl.sv
module i2c_trig_ctl
  import i2c_trig_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 40,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        cfgMode,
  input  logic [1:0]        cfgAddrWidth,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgDirRead,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  busEv_t            ev,
  input  logic [3:0]        bitCnt,
  input  logic [2:0]        byteCnt,
  input  logic [7:0]        curByte,
  input  logic [IDX_W-1:0]  dataIdx,
  input  logic              dataOk,
  input  logic              patBitOk,
  output ctlStrobe_t        strobe,
  output logic              trigOut
);

  trigMode_e  mode;
  addrWidth_e aw;
  assign mode = trigMode_e'(cfgMode);
  assign aw   = addrWidth_e'(cfgAddrWidth);

  logic             active, addrHiOk, addrHit;
  logic             bitDone, ackBit, byteLast, addrNow, dataNow, fire;
  logic             match7, match8, hi10;
  logic [2:0]       dataStart;
  logic [IDX_W-1:0] lenBits;

  assign lenBits   = IDX_W'({cfgDataLen, 3'b000});
  assign dataStart = (aw == AW_10) ? 3'd2 : 3'd1;

  assign bitDone  = ev.sclRise & active & (bitCnt != 4'd8);
  assign ackBit   = ev.sclRise & active & (bitCnt == 4'd8);
  assign byteLast = bitDone & (bitCnt == 4'd7);

  assign match7 = curByte == {cfgAddr[6:0], cfgDirRead};
  assign match8 = curByte == cfgAddr[7:0];
  assign hi10   = curByte == {5'b11110, cfgAddr[ADDR_W-1 -: 2], cfgDirRead};

  always_comb begin
    unique case (aw)
      AW_7:    addrNow = byteLast & (byteCnt == 3'd0) & match7;
      AW_8:    addrNow = byteLast & (byteCnt == 3'd0) & match8;
      AW_10:   addrNow = byteLast & (byteCnt == 3'd1) & addrHiOk & match8;
      default: addrNow = 1'b0;
    endcase
  end

  assign strobe.clrFrame = ev.startEv | ev.stopEv;
  assign strobe.dataBit  = bitDone & (byteCnt >= dataStart) & (dataIdx < lenBits)
                         & (dataIdx < IDX_W'(DATA_W));
  assign dataNow = strobe.dataBit & dataOk & patBitOk & (dataIdx == lenBits - IDX_W'(1));

  always_comb begin
    unique case (mode)
      TRG_STOP:      fire = ev.stopEv;
      TRG_NACK:      fire = ackBit & ev.sdaBit;
      TRG_ADDR:      fire = addrNow;
      TRG_DATA:      fire = dataNow;
      TRG_ADDR_DATA: fire = dataNow & addrHit;
      default:       fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      addrHiOk <= 1'b0;
      addrHit  <= 1'b0;
      trigOut  <= 1'b0;
    end else begin
      trigOut <= fire;
      if (ev.startEv)     active <= 1'b1;
      else if (ev.stopEv) active <= 1'b0;
      if (strobe.clrFrame) begin
        addrHiOk <= 1'b0;
        addrHit  <= 1'b0;
      end else begin
        if (byteLast && byteCnt == 3'd0) addrHiOk <= hi10;
        if (addrNow) addrHit <= 1'b1;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  a_r4_stop_levels: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && cfgMode == 3'd0) |-> $past(sclIn && sdaIn));

  a_r5_nack_high: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut && cfgMode == 3'd1) |-> $past(sdaIn && sclIn));

endmodule

// File: rtl/i2c_trig_det.sv
module i2c_trig_det
  import i2c_trig_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_BYTES = 5,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int IDX_W     = $clog2(DATA_W + 1),
  localparam int LEN_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        cfgMode,
  input  logic [1:0]        cfgAddrWidth,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgDirRead,
  input  logic [LEN_W-1:0]  cfgDataLen,
  input  logic [DATA_W-1:0] cfgDataVal,
  input  logic [DATA_W-1:0] cfgDataCare,
  output logic              trigOut
);

  busEv_t           ev;
  ctlStrobe_t       strobe;
  logic [3:0]       bitCnt;
  logic [2:0]       byteCnt;
  logic [7:0]       curByte;
  logic [IDX_W-1:0] dataIdx;
  logic             dataOk, patBitOk;

  i2c_trig_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgDataVal(cfgDataVal), .cfgDataCare(cfgDataCare),
    .strobe(strobe), .ev(ev), .bitCnt(bitCnt), .byteCnt(byteCnt),
    .curByte(curByte), .dataIdx(dataIdx), .dataOk(dataOk), .patBitOk(patBitOk)
  );

  i2c_trig_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cfgMode(cfgMode), .cfgAddrWidth(cfgAddrWidth), .cfgAddr(cfgAddr),
    .cfgDirRead(cfgDirRead), .cfgDataLen(cfgDataLen),
    .ev(ev), .bitCnt(bitCnt), .byteCnt(byteCnt), .curByte(curByte),
    .dataIdx(dataIdx), .dataOk(dataOk), .patBitOk(patBitOk),
    .strobe(strobe), .trigOut(trigOut)
  );

endmodule

// File: tb/i2c_trig_det_bench.sv
`timescale 1ns/1ps
module i2c_trig_det_bench;

  localparam int STOP_TAG  = 1000;
  localparam int START_TAG = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1, sda = 1'b1;
  logic [2:0]  cfgMode = '0;
  logic [1:0]  cfgAddrWidth = '0;
  logic [9:0]  cfgAddr = '0;
  logic        cfgDirRead = 1'b0;
  logic [2:0]  cfgDataLen = 3'd1;
  logic [39:0] cfgDataVal = '0, cfgDataCare = '0;
  logic        trigOut;

  int nChecks = 0, nFail = 0;
  int curTag = START_TAG;
  int gotCount = 0, gotFirst = -1;
  bit done = 1'b0;

  logic [7:0] tb_bytes [8];
  logic       tb_acks  [8];
  int         tn;

  always #10 clk = ~clk;

  i2c_trig_det u_i2c_trig_det (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sda),
    .cfgMode(cfgMode), .cfgAddrWidth(cfgAddrWidth), .cfgAddr(cfgAddr),
    .cfgDirRead(cfgDirRead), .cfgDataLen(cfgDataLen),
    .cfgDataVal(cfgDataVal), .cfgDataCare(cfgDataCare), .trigOut(trigOut)
  );

  always @(negedge clk) begin
    if (rstN && trigOut) begin
      if (gotCount == 0) gotFirst = curTag;
      gotCount++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busSet(input logic s, input logic d, input int tag);
    @(negedge clk);
    scl = s; sda = d; curTag = tag;
    @(negedge clk);
  endtask

  task automatic sendStart();
    busSet(1'b0, 1'b1, START_TAG);
    busSet(1'b1, 1'b1, START_TAG);
    busSet(1'b1, 1'b0, START_TAG);
  endtask

  task automatic sendStop();
    busSet(1'b0, 1'b0, STOP_TAG);
    busSet(1'b1, 1'b0, STOP_TAG);
    busSet(1'b1, 1'b1, STOP_TAG);
  endtask

  task automatic sendBit(input logic b, input int tag);
    busSet(1'b0, b, tag);
    busSet(1'b1, b, tag);
    busSet(1'b0, b, tag);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic ack, input int idx);
    for (int i = 7; i >= 0; i--) sendBit(v[i], idx * 16 + (7 - i));
    sendBit(ack, idx * 16 + 8);
  endtask

  function automatic bit addrOk();
    case (cfgAddrWidth)
      2'd0: return tn >= 1 && tb_bytes[0] == {cfgAddr[6:0], cfgDirRead};
      2'd1: return tn >= 1 && tb_bytes[0] == cfgAddr[7:0];
      default: return tn >= 2 && tb_bytes[0] == {5'b11110, cfgAddr[9:8], cfgDirRead}
                      && tb_bytes[1] == cfgAddr[7:0];
    endcase
  endfunction

  function automatic int addrTag();
    return (cfgAddrWidth == 2'd2) ? 16 + 7 : 7;
  endfunction

  function automatic bit dataOkRef();
    int ds = (cfgAddrWidth == 2'd2) ? 2 : 1;
    int len = int'(cfgDataLen);
    if (tn < ds + len) return 1'b0;
    for (int k = 0; k < 8 * len; k++) begin
      logic b = tb_bytes[ds + k / 8][7 - (k % 8)];
      if (cfgDataCare[k] && b != cfgDataVal[k]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int dataTag();
    int ds = (cfgAddrWidth == 2'd2) ? 2 : 1;
    return (ds + int'(cfgDataLen) - 1) * 16 + 7;
  endfunction

  function automatic string reqOf();
    case (cfgMode)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return (cfgAddrWidth == 2'd0) ? "R6" : (cfgAddrWidth == 2'd1) ? "R7" : "R8";
      3'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic expected(output int cnt, output int first);
    cnt = 0; first = -1;
    case (cfgMode)
      3'd0: begin cnt = 1; first = STOP_TAG; end
      3'd1: for (int i = 0; i < tn; i++)
              if (tb_acks[i]) begin
                if (cnt == 0) first = i * 16 + 8;
                cnt++;
              end
      3'd2: if (addrOk()) begin cnt = 1; first = addrTag(); end
      3'd3: if (dataOkRef()) begin cnt = 1; first = dataTag(); end
      default: if (addrOk() && dataOkRef()) begin cnt = 1; first = dataTag(); end
    endcase
  endtask

  task automatic runTxn(input string note);
    int ec, ef;
    gotCount = 0; gotFirst = -1;
    sendStart();
    for (int i = 0; i < tn; i++) sendByte(tb_bytes[i], tb_acks[i], i);
    sendStop();
    repeat (3) @(negedge clk);
    expected(ec, ef);
    check($sformatf("%s/R2 count %s", reqOf(), note), gotCount, ec);
    check($sformatf("%s position %s", reqOf(), note), gotFirst, ef);
  endtask

  task automatic randTxn();
    int nAddr, len;
    cfgMode      = 3'($urandom % 5);
    cfgAddrWidth = 2'($urandom % 3);
    cfgAddr      = 10'($urandom);
    cfgDirRead   = 1'($urandom);
    cfgDataLen   = 3'(1 + $urandom % 5);
    cfgDataVal   = {8'($urandom), 32'($urandom)};
    cfgDataCare  = {8'($urandom), 32'($urandom)} & {8'($urandom), 32'($urandom)};
    nAddr = (cfgAddrWidth == 2'd2) ? 2 : 1;
    len = int'(cfgDataLen);
    tn = nAddr + len + int'($urandom % 2) - int'($urandom % 4 == 0);
    if (tn < 1) tn = 1;
    if (tn > 8) tn = 8;
    for (int i = 0; i < 8; i++) begin
      tb_bytes[i] = 8'($urandom);
      tb_acks[i]  = ($urandom % 6 == 0);
    end
    if ($urandom % 3 != 0) begin
      case (cfgAddrWidth)
        2'd0: tb_bytes[0] = {cfgAddr[6:0], cfgDirRead ^ ($urandom % 5 == 0)};
        2'd1: tb_bytes[0] = cfgAddr[7:0];
        default: begin
          tb_bytes[0] = {5'b11110, cfgAddr[9:8], cfgDirRead};
          tb_bytes[1] = cfgAddr[7:0];
        end
      endcase
    end
    if ($urandom % 2 == 0) begin
      for (int k = 0; k < 8 * len; k++)
        if (cfgDataCare[k] && nAddr + k / 8 < 8)
          tb_bytes[nAddr + k / 8][7 - (k % 8)] = cfgDataVal[k];
    end
    runTxn("random");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 trig in reset", int'(trigOut), 0);
    rstN = 1'b1;
    gotCount = 0;
    repeat (10) @(negedge clk);
    check("R1 idle after reset", gotCount, 0);

    // R7: 8-bit address, direction setting has no effect
    cfgMode = 3'd2; cfgAddrWidth = 2'd1; cfgAddr = 10'h0A5; cfgDirRead = 1'b1;
    tn = 2; tb_bytes[0] = 8'hA5; tb_bytes[1] = 8'h3C; tb_acks[0] = 0; tb_acks[1] = 0;
    runTxn("8bit dir=1");
    cfgDirRead = 1'b0;
    runTxn("8bit dir=0");

    // R8: 10-bit with and without the 11110 prefix
    cfgAddrWidth = 2'd2; cfgAddr = 10'h2D3; cfgDirRead = 1'b0;
    tn = 3; tb_bytes[0] = 8'b11110100; tb_bytes[1] = 8'hD3; tb_bytes[2] = 8'h00;
    tb_acks[2] = 0;
    runTxn("10bit match");
    tb_bytes[0] = 8'b11100100;
    runTxn("10bit bad prefix");

    // R3: repeated start re-arms address decoding
    cfgAddrWidth = 2'd0; cfgAddr = 10'h02C; cfgDirRead = 1'b0;
    gotCount = 0; gotFirst = -1;
    sendStart();
    sendBit(1'b0, 500); sendBit(1'b1, 501); sendBit(1'b0, 502); sendBit(1'b1, 503);
    sendStart();
    sendByte(8'h58, 1'b0, 0);
    sendStop();
    repeat (3) @(negedge clk);
    check("R3 restart count", gotCount, 1);
    check("R3 restart position", gotFirst, 7);

    // R9: all-don't-care single byte fires on the last data bit
    cfgMode = 3'd3; cfgDataLen = 3'd1; cfgDataCare = '0;
    tn = 2; tb_bytes[0] = 8'h11; tb_bytes[1] = 8'hE7; tb_acks[0] = 1; tb_acks[1] = 1;
    runTxn("dont care");

    // R5: several lost acknowledges in one transfer
    cfgMode = 3'd1;
    tn = 3; tb_acks[0] = 0; tb_acks[1] = 1; tb_acks[2] = 1;
    runTxn("multi nack");

    // R10: data matches but address does not
    cfgMode = 3'd4; cfgDataLen = 3'd1; cfgDataCare = 40'hFF; cfgDataVal = 40'h5A;
    cfgAddrWidth = 2'd0; cfgAddr = 10'h011; cfgDirRead = 1'b1;
    tn = 2; tb_bytes[0] = 8'h23; tb_bytes[1] = 8'h5A; tb_acks[0] = 0; tb_acks[1] = 0;
    runTxn("addr ok");
    tb_bytes[0] = 8'h22;
    runTxn("addr wrong");

    for (int n = 0; n < 110; n++) randTxn();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule